// File: doc/BRIEF.md
# Serial Command Interface for a Segment Display Controller

This block is the host-facing side of a multiplexed segment display controller. It listens on a two-wire I2C bus as a target, decodes a protocol in which each command code is followed by one setting byte, and keeps the configuration that the panel drive sequencer uses: the number of commons and the bias level, the oscillator and display enables, the frame rate, the blink rate, and the voltage-adjust settings. It also holds the sixteen-byte display memory. The sequencer reads that memory through its own combinational port, while the host reads and writes it through an address pointer that advances by itself.

SCL and SDA arrive as raw levels and are resampled in the system clock domain. The block drives SDA only through a pull-down enable, which the pad turns into an open-drain output. One bus transfer may carry several command/setting pairs in a row. The display-data command hands the rest of the transfer over to memory data.

The pointer moves on the acknowledge clock of each byte. The point at which it wraps back to zero depends on the selected number of commons. For a read, the host sets the pointer in a write transfer, then issues a repeated START and the read address.

Top module: `lcdi2c_ctrl`

## Requirements
- R1: After reset the block selects 4 commons (`duty_o`=0), 1/3 bias (`bias_o`=0), oscillator and display off, 80 Hz frame (`frame_fast_o`=0), blink off (`blink_o`=00), shared pin as segment (`seg_pin_o`=1), voltage adjust enabled (`vadj_en_o`=1), level 0, pointer 0, and every display byte 0.
- R2: The block acknowledges only the address byte 0x70 (write) or 0x71 (read), that is the target address 0111000 followed by the direction bit. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R3: In a write transfer to the block, every byte is acknowledged: command bytes, setting bytes and data bytes alike.
- R4: Command 0x82 loads `duty_o` from setting bit 1 (1 = 8 commons) and `bias_o` from setting bit 0 (1 = 1/4 bias).
- R5: Command 0x84 loads S from setting bit 1 and E from setting bit 0. `osc_on_o` = S and `disp_on_o` = S and E, so S=0 turns both off whatever E is.
- R6: Command 0x86 loads `frame_fast_o` from setting bit 0 (1 = 160 Hz). Command 0x88 loads `blink_o` from setting bits 1:0 (00 off, 01 2 Hz, 10 1 Hz, 11 0.5 Hz).
- R7: Command 0x94 loads `seg_pin_o` from setting bit 5, `vadj_en_o` from bit 4 and `vadj_lvl_o` from bits 3:0.
- R8: A command code other than 0x80, 0x82, 0x84, 0x86, 0x88 or 0x94 changes no configuration output.
- R9: Command 0x80 loads the pointer from bits 3:0 of its setting byte. Each data byte that follows is written at the pointer, and the pointer then advances on that byte's acknowledge clock. `lcd_rdata_o` shows the byte at `lcd_raddr_i` in the same cycle.
- R10: The pointer returns to 0 after 0x09 when `duty_o`=0 and after 0x0F when `duty_o`=1. This applies to both writes and reads.
- R11: In a read transfer the byte at the pointer is sent MSB first, with SDA released for every 1 bit. The pointer advances only when the host acknowledges. A not-acknowledge ends the read and leaves the pointer unchanged.
- R12: A START or STOP in the middle of a byte discards that byte. The block then waits for an address, and no configuration changes.
- R13: After a setting byte for any command other than 0x80, the next byte in the same transfer is decoded as a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock level |
| sda_i | input | 1 | Raw serial data level as seen on the wire |
| sda_pd_o | output | 1 | Enable for the SDA pull-down |
| duty_o | output | 1 | 0 = 4 commons, 1 = 8 commons |
| bias_o | output | 1 | 0 = 1/3 bias, 1 = 1/4 bias |
| osc_on_o | output | 1 | Oscillator enable |
| disp_on_o | output | 1 | Display enable |
| frame_fast_o | output | 1 | 0 = 80 Hz frame, 1 = 160 Hz frame |
| blink_o | output | 2 | Blink rate code |
| seg_pin_o | output | 1 | Shared pin acts as segment (1) or voltage pin (0) |
| vadj_en_o | output | 1 | Internal voltage adjust enable |
| vadj_lvl_o | output | 4 | Voltage adjust step |
| lcd_raddr_i | input | 4 | Sequencer read address |
| lcd_rdata_o | output | 8 | Display byte at the sequencer read address |

## Verification
On the acknowledge clock of a data byte at the wrap boundary, two things happen in the same cycle: the byte is written at the last address, and the pointer resets to zero. A burst that starts one location below the limit provokes this. The burst is run once with 4 commons (limit 0x09) and once with 8 commons (limit 0x0F). The sequencer port then shows the boundary location holding its byte, the next byte landing at location 0, and the location just past the 4-common limit untouched. A read burst that crosses 0x0F, followed by a NACK, confirms the same pointer behaviour from the read side.

// File: rtl/lcdi2c_pkg.sv
package lcdi2c_pkg;

    localparam int PTR_W     = 4;
    localparam int DATA_W    = 8;
    localparam int MEM_DEPTH = 16;
    localparam int BIT_W     = $clog2(DATA_W + 1);
    localparam int SET_W     = 6;

    localparam logic [6:0] SLV_ADDR = 7'b0111000;

    localparam logic [7:0] CMD_PTR   = 8'h80;
    localparam logic [7:0] CMD_DRIVE = 8'h82;
    localparam logic [7:0] CMD_SYS   = 8'h84;
    localparam logic [7:0] CMD_FRAME = 8'h86;
    localparam logic [7:0] CMD_BLINK = 8'h88;
    localparam logic [7:0] CMD_VADJ  = 8'h94;

    localparam logic [PTR_W-1:0] LIM_QUARTER = PTR_W'(9);
    localparam logic [PTR_W-1:0] LIM_EIGHTH  = PTR_W'(15);

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_CMD, PH_ARG, PH_WDATA, PH_RDATA
    } phase_e;

    typedef struct packed {
        logic       duty8;
        logic       bias4;
        logic       sys_s;
        logic       sys_e;
        logic       frame_fast;
        logic [1:0] blink;
        logic       seg_pin;
        logic       vadj_en;
        logic [3:0] vadj_lvl;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{duty8: 1'b0, bias4: 1'b0, sys_s: 1'b0,
                                   sys_e: 1'b0, frame_fast: 1'b0, blink: 2'b00,
                                   seg_pin: 1'b1, vadj_en: 1'b1, vadj_lvl: 4'h0};

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic duty8);
        logic [PTR_W-1:0] lim;
        lim = duty8 ? LIM_EIGHTH : LIM_QUARTER;
        return (p == lim) ? '0 : p + 1'b1;
    endfunction

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_PTR) || (c == CMD_DRIVE) || (c == CMD_SYS) ||
               (c == CMD_FRAME) || (c == CMD_BLINK) || (c == CMD_VADJ);
    endfunction

endpackage

// File: rtl/lcdi2c_line_sync.sv
module lcdi2c_line_sync
    import lcdi2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev_o.rise  = scl_s & ~scl_p;
        ev_o.fall  = ~scl_s & scl_p;
        ev_o.start = scl_s & scl_p & sda_p & ~sda_s;
        ev_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev_o.sda   = sda_s;
        ev_o.scl   = scl_s;
    end
endmodule

// File: rtl/lcdi2c_dmem.sv
module lcdi2c_dmem #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] row [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                row[i] <= '0;
            else if (we && waddr == AW'(i))
                row[i] <= wdata;
        end
    end

    assign rdata_a = row[raddr_a];
    assign rdata_b = row[raddr_b];

    // R9
    mem_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && raddr_b == $past(waddr)) |-> rdata_b == $past(wdata));
endmodule

// File: rtl/lcdi2c_cfg.sv
module lcdi2c_cfg
    import lcdi2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             apply,
    input  logic [7:0]       cmd,
    input  logic [SET_W-1:0] arg,
    output cfg_t             cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (apply) begin
            case (cmd)
                CMD_DRIVE: begin
                    cfg_q.duty8 <= arg[1];
                    cfg_q.bias4 <= arg[0];
                end
                CMD_SYS: begin
                    cfg_q.sys_s <= arg[1];
                    cfg_q.sys_e <= arg[0];
                end
                CMD_FRAME: cfg_q.frame_fast <= arg[0];
                CMD_BLINK: cfg_q.blink      <= arg[1:0];
                CMD_VADJ: begin
                    cfg_q.seg_pin  <= arg[5];
                    cfg_q.vadj_en  <= arg[4];
                    cfg_q.vadj_lvl <= arg[3:0];
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!apply || !cmd_known(cmd)) |-> cfg_q == $past(cfg_q));
endmodule

// File: rtl/lcdi2c_proto.sv
module lcdi2c_proto
    import lcdi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              duty8,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_pd,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              cfg_apply,
    output logic [7:0]        cfg_cmd,
    output logic [SET_W-1:0]  cfg_arg
);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);
    localparam logic [2:0]       MSB_IDX  = 3'(DATA_W - 1);

    phase_e            phase;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic [7:0]        cmd_q;
    logic              ack_clk, ptr_adv, ptr_load, addr_hit;

    assign addr_hit  = (shreg[7:1] == SLV_ADDR);
    assign ack_clk   = ev.rise && (bitcnt == ACK_SLOT);
    assign wr_en     = ack_clk && (phase == PH_WDATA);
    assign cfg_apply = ack_clk && (phase == PH_ARG);
    assign ptr_load  = cfg_apply && (cmd_q == CMD_PTR);
    assign ptr_adv   = wr_en || (ack_clk && phase == PH_RDATA && !ev.sda);
    assign wr_data   = shreg;
    assign cfg_cmd   = cmd_q;
    assign cfg_arg   = shreg[SET_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            cmd_q  <= '0;
            sda_pd <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sda_pd <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            sda_pd <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (ev.rise) begin
                if (bitcnt != ACK_SLOT) begin
                    shreg  <= {shreg[DATA_W-2:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end else begin
                    bitcnt <= '0;
                    case (phase)
                        PH_ADDR:  phase <= !addr_hit ? PH_IDLE :
                                           (shreg[0] ? PH_RDATA : PH_CMD);
                        PH_CMD: begin
                            cmd_q <= shreg;
                            phase <= PH_ARG;
                        end
                        PH_ARG:   phase <= (cmd_q == CMD_PTR) ? PH_WDATA : PH_CMD;
                        PH_RDATA: if (ev.sda) phase <= PH_IDLE;
                        default: ;
                    endcase
                end
            end else if (ev.fall) begin
                if (bitcnt == ACK_SLOT)
                    sda_pd <= (phase == PH_ADDR) ? addr_hit : (phase != PH_RDATA);
                else if (phase == PH_RDATA)
                    sda_pd <= ~rd_data[MSB_IDX - bitcnt[2:0]];
                else
                    sda_pd <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr_load)
            ptr <= shreg[PTR_W-1:0];
        else if (ptr_adv)
            ptr <= ptr_next(ptr, duty8);
    end

    // R2
    addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_pd) && $past(phase) == PH_ADDR) |-> $past(shreg[7:1]) == SLV_ADDR);

    // R10
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ptr_adv) && $past(ptr) == ($past(duty8) ? LIM_EIGHTH : LIM_QUARTER))
        |-> ptr == '0);

    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(ptr_adv) && !$past(ptr_load)) |-> ptr == $past(ptr));

    // R12
    sda_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pd) && !$past(ev.start || ev.stop)) |-> !$past(ev.scl));
endmodule

// File: rtl/lcdi2c_ctrl.sv
module lcdi2c_ctrl
    import lcdi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pd_o,
    output logic       duty_o,
    output logic       bias_o,
    output logic       osc_on_o,
    output logic       disp_on_o,
    output logic       frame_fast_o,
    output logic [1:0] blink_o,
    output logic       seg_pin_o,
    output logic       vadj_en_o,
    output logic [3:0] vadj_lvl_o,
    input  logic [3:0] lcd_raddr_i,
    output logic [7:0] lcd_rdata_o
);
    bus_ev_t           ev;
    cfg_t              cfg;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en, cfg_apply;
    logic [DATA_W-1:0] wr_data, ptr_data;
    logic [7:0]        cfg_cmd;
    logic [SET_W-1:0]  cfg_arg;

    lcdi2c_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    lcdi2c_proto u_proto (
        .clk(clk), .rst(rst), .ev(ev), .duty8(cfg.duty8), .rd_data(ptr_data),
        .sda_pd(sda_pd_o), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_apply(cfg_apply), .cfg_cmd(cfg_cmd), .cfg_arg(cfg_arg)
    );

    lcdi2c_cfg u_cfg (
        .clk(clk), .rst(rst), .apply(cfg_apply), .cmd(cfg_cmd),
        .arg(cfg_arg), .cfg_o(cfg)
    );

    lcdi2c_dmem #(.DEPTH(MEM_DEPTH), .DW(DATA_W)) u_mem (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(ptr), .wdata(wr_data),
        .raddr_a(ptr), .rdata_a(ptr_data),
        .raddr_b(lcd_raddr_i), .rdata_b(lcd_rdata_o)
    );

    assign duty_o       = cfg.duty8;
    assign bias_o       = cfg.bias4;
    assign osc_on_o     = cfg.sys_s;
    assign disp_on_o    = cfg.sys_s & cfg.sys_e;
    assign frame_fast_o = cfg.frame_fast;
    assign blink_o      = cfg.blink;
    assign seg_pin_o    = cfg.seg_pin;
    assign vadj_en_o    = cfg.vadj_en;
    assign vadj_lvl_o   = cfg.vadj_lvl;

    // R5
    disp_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        disp_on_o |-> osc_on_o);
endmodule

// File: tb/lcdi2c_ctrl_tb_top.sv
module lcdi2c_ctrl_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pd_o, duty_o, bias_o, osc_on_o, disp_on_o, frame_fast_o;
    logic       seg_pin_o, vadj_en_o;
    logic [1:0] blink_o;
    logic [3:0] vadj_lvl_o, lcd_raddr = 4'h0;
    logic [7:0] lcd_rdata_o;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_pd_o;

    lcdi2c_ctrl dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pd_o(sda_pd_o),
        .duty_o(duty_o), .bias_o(bias_o), .osc_on_o(osc_on_o), .disp_on_o(disp_on_o),
        .frame_fast_o(frame_fast_o), .blink_o(blink_o), .seg_pin_o(seg_pin_o),
        .vadj_en_o(vadj_en_o), .vadj_lvl_o(vadj_lvl_o),
        .lcd_raddr_i(lcd_raddr), .lcd_rdata_o(lcd_rdata_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(); wait_q();
    endtask

    task automatic bit_io(input logic b, output logic r);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        r = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(d[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(~mack, r);
    endtask

    task automatic cmd_write(input logic [7:0] c, input logic [7:0] a, input string tag);
        logic k0, k1, k2;
        bus_start();
        send_byte(8'h70, k0);
        send_byte(c, k1);
        send_byte(a, k2);
        bus_stop();
        check({tag, " R3 acks"}, {k0, k1, k2}, 3'b111);
    endtask

    task automatic mem_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        lcd_raddr = a;
        @(negedge clk);
        check(tag, lcd_rdata_o, exp);
    endtask

    task automatic write_burst(input logic [3:0] p, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2);
        logic k;
        bus_start();
        send_byte(8'h70, k);
        send_byte(8'h80, k);
        send_byte({4'h0, p}, k);
        send_byte(d0, k);
        send_byte(d1, k);
        send_byte(d2, k);
        check("R3 data ack", k, 1'b1);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 cfg", {duty_o, bias_o, osc_on_o, disp_on_o, frame_fast_o, blink_o,
                         seg_pin_o, vadj_en_o, vadj_lvl_o}, 13'b0000000_11_0000);
        check("R1 sda", sda_pd_o, 1'b0);
        mem_chk("R1 mem0", 4'h0, 8'h00);
        mem_chk("R1 mem15", 4'hF, 8'h00);
    endtask

    task automatic t_addr();
        logic k0, k1, k2;
        bus_start();
        send_byte(8'h72, k0);
        send_byte(8'h82, k1);
        send_byte(8'h03, k2);
        bus_stop();
        check("R2 foreign address nack", {k0, k1, k2}, 3'b000);
        check("R2 foreign transfer ignored", {duty_o, bias_o}, 2'b00);
    endtask

    task automatic t_modes();
        cmd_write(8'h82, 8'hF3, "R4");
        check("R4 duty/bias", {duty_o, bias_o}, 2'b11);
        cmd_write(8'h82, 8'h01, "R4");
        check("R4 duty/bias 01", {duty_o, bias_o}, 2'b01);
        cmd_write(8'h84, 8'h01, "R5");
        check("R5 S=0 E=1", {osc_on_o, disp_on_o}, 2'b00);
        cmd_write(8'h84, 8'h02, "R5");
        check("R5 S=1 E=0", {osc_on_o, disp_on_o}, 2'b10);
        cmd_write(8'h84, 8'h03, "R5");
        check("R5 S=1 E=1", {osc_on_o, disp_on_o}, 2'b11);
        cmd_write(8'h86, 8'h01, "R6");
        check("R6 frame", frame_fast_o, 1'b1);
        cmd_write(8'h88, 8'h03, "R6");
        check("R6 blink", blink_o, 2'b11);
        cmd_write(8'h94, 8'hCA, "R7");
        check("R7 vadj", {seg_pin_o, vadj_en_o, vadj_lvl_o}, 6'b00_1010);
        cmd_write(8'h94, 8'h25, "R7");
        check("R7 vadj 2", {seg_pin_o, vadj_en_o, vadj_lvl_o}, 6'b10_0101);
    endtask

    task automatic t_undef();
        cmd_write(8'h8A, 8'hFF, "R8");
        cmd_write(8'h83, 8'h00, "R8");
        check("R8 undefined commands", {duty_o, bias_o, osc_on_o, disp_on_o, frame_fast_o,
              blink_o, seg_pin_o, vadj_en_o, vadj_lvl_o}, 13'b0111111_10_0101);
    endtask

    task automatic t_chain();
        logic k;
        bus_start();
        send_byte(8'h70, k);
        send_byte(8'h86, k);
        send_byte(8'h00, k);
        send_byte(8'h88, k);
        send_byte(8'h01, k);
        bus_stop();
        check("R13 chained commands", {frame_fast_o, blink_o}, 3'b001);
    endtask

    task automatic t_write4();
        cmd_write(8'h82, 8'h00, "R10");
        write_burst(4'h8, 8'hA1, 8'hA2, 8'hA3);
        mem_chk("R9 mem8", 4'h8, 8'hA1);
        mem_chk("R10 mem9", 4'h9, 8'hA2);
        mem_chk("R10 wrap to 0 (4 commons)", 4'h0, 8'hA3);
        mem_chk("R10 mem10 untouched", 4'hA, 8'h00);
    endtask

    task automatic t_write8();
        cmd_write(8'h82, 8'h02, "R10");
        write_burst(4'hE, 8'hC1, 8'hC2, 8'hC3);
        mem_chk("R9 mem14", 4'hE, 8'hC1);
        mem_chk("R10 mem15", 4'hF, 8'hC2);
        mem_chk("R10 wrap to 0 (8 commons)", 4'h0, 8'hC3);
    endtask

    task automatic t_read();
        logic       k0, k1, k2, k3;
        logic [7:0] d0, d1;
        bus_start();
        send_byte(8'h70, k0);
        send_byte(8'h80, k1);
        send_byte(8'h0E, k2);
        bus_start();
        send_byte(8'h71, k3);
        check("R2 read address ack", {k0, k1, k2, k3}, 4'b1111);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        check("R11 read byte 0", d0, 8'hC1);
        check("R11 read byte 1", d1, 8'hC2);
        bus_start();
        send_byte(8'h71, k0);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        check("R11 no advance on nack", d0, 8'hC2);
        check("R10 read wrap", d1, 8'hC3);
    endtask

    task automatic t_abort();
        logic k, r;
        bus_start();
        send_byte(8'h70, k);
        send_byte(8'h88, k);
        for (int i = 0; i < 4; i++) bit_io(1'b1, r);
        bus_start();
        send_byte(8'h70, k);
        check("R12 address after restart", k, 1'b1);
        send_byte(8'h86, k);
        for (int i = 0; i < 3; i++) bit_io(1'b1, r);
        bus_stop();
        check("R12 aborted bytes", {frame_fast_o, blink_o}, 3'b001);
        cmd_write(8'h88, 8'h02, "R12");
        check("R12 recovers", blink_o, 2'b10);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_addr();
        t_modes();
        t_undef();
        t_chain();
        t_write4();
        t_write8();
        t_read();
        t_abort();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end
endmodule